// File: doc/BRIEF.md
# I2C Write Target with Software ACK Hold

This block is the receive side of an I2C target. It handles write transfers with 7-bit addresses only. SCL and SDA come in as plain levels and pass through a synchroniser. The block drives each line low through an output enable, so the pads or the bench wired-AND them with the other bus agents. Start and stop conditions restart and end its byte framing. An address byte equal to the target's own address with the direction bit at 0 is accepted. Each accepted byte is placed in a single receive buffer, and the block raises an interrupt flag that stays set until software clears it.

A host controller runs the block through level configuration inputs and single-cycle command pulses. The host can ask the block to pause the bus after the eighth SCL falling edge of an address byte, a data byte, or both. During that pause the host inspects the byte and sets the ACK level it wants driven in the ninth bit. The host can also ask for SCL to be stretched after every acknowledged byte. A full buffer or a pending overflow makes the block reply NACK on its own, unless the host allows overwriting of a full buffer.

Top module: `i2c_rx_hold`

## Requirements
- R1: After reset, both line enables are off, and the buffer-full, overflow, interrupt, ack-time, start-seen and stop-seen flags are 0. The clock-release flag is 1.
- R2: SDA falling while SCL is high is a start. It sets start-seen, clears stop-seen and sets the interrupt only when start interrupts are enabled. SDA rising while SCL is high is a stop. It sets stop-seen, clears start-seen, returns the block to idle and sets the interrupt only when stop interrupts are enabled.
- R3: The first byte after a start is acknowledged only when it equals {own_addr_i, 1'b0}. In that case it is loaded into the buffer and buffer-full is set. Any other first byte is NACKed (SDA left released), and the buffer and the interrupt are left alone.
- R4: After an accepted address, each data byte that is accepted is loaded into the buffer, sets buffer-full and is acknowledged by pulling SDA low in the ninth bit.
- R5: If a byte completes while buffer-full is 1 and buffer override is off, the block sets overflow, replies NACK and keeps the old buffer contents. While overflow is 1, every byte is NACKed and not loaded.
- R6: With buffer override on, a full buffer does not force a NACK. The new byte replaces the buffer contents and is acknowledged, and overflow stays 0.
- R7: The interrupt flag is set on the ninth SCL falling edge of every acknowledged byte and is not set after a NACKed byte. Once set, it stays set until irq_clr_i.
- R8: With stretch enabled, SCL is held low from the ninth falling edge of each acknowledged byte, and clock-release is cleared. SCL stays low until release_i.
- R9: With address hold (for the address byte) or data hold (for data bytes) enabled, an accepted byte at its eighth SCL falling edge sets the interrupt and ack-time, clears clock-release and holds SCL low. After release_i, the ninth bit carries ack_data_i (0 = ACK, SDA low; 1 = NACK, SDA released). A byte refused by R5 is NACKed with no hold.
- R10: Ack-time is cleared on the ninth SCL falling edge and on any start or stop.
- R11: A rd_buf_i pulse clears buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 7 | Target address |
| addr_hold_en_i | input | 1 | Pause after the eighth edge of the address byte |
| data_hold_en_i | input | 1 | Pause after the eighth edge of data bytes |
| stretch_en_i | input | 1 | Stretch SCL after every acknowledged byte |
| buf_ovr_en_i | input | 1 | Let a new byte overwrite a full buffer |
| start_irq_en_i | input | 1 | Interrupt on start |
| stop_irq_en_i | input | 1 | Interrupt on stop |
| ack_data_i | input | 1 | ACK level used after a hold (0 = ACK) |
| release_i | input | 1 | Pulse: set clock-release |
| rd_buf_i | input | 1 | Pulse: buffer read, clears buffer-full |
| irq_clr_i | input | 1 | Pulse: clear interrupt |
| ovf_clr_i | input | 1 | Pulse: clear overflow |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Buffer-full flag |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt flag |
| clk_rel_o | output | 1 | Clock-release flag |
| ack_time_o | output | 1 | Interrupt came at the ACK phase (eighth edge) |
| start_seen_o | output | 1 | Last bus condition was a start |
| stop_seen_o | output | 1 | Last bus condition was a stop |

## Verification
The hardest situation to reach is a byte completing while the block is already holding SCL low. The bus master can only move forward once the host has released the clock. To get there, the bench runs a bit-level open-drain master that waits on the real wired-AND SCL level. The bench interleaves host pulses between bytes and sweeps all eight hold and stretch combinations, each with an ACK and a NACK choice for the data byte. Overflow is reached by leaving the buffer unread across two data bytes. A separate sweep of all 128 addresses exercises address matching.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_HOLD8,
    ST_ACK,
    ST_HOLD9,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_s      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edges only count as conditions while SCL is steadily high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i && cnt_q != CNT_FULL) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
    end
  end

  assign byte_o = sh_q;
  assign done_o = scl_fall_i && (cnt_q == CNT_FULL);
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr_hold_en_i,
  input  logic              data_hold_en_i,
  input  logic              stretch_en_i,
  input  logic              buf_ovr_en_i,
  input  logic              start_irq_en_i,
  input  logic              stop_irq_en_i,
  input  logic              ack_data_i,
  input  logic              release_i,
  input  logic              rd_buf_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic              next_byte_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              clk_rel_o,
  output logic              ack_time_o,
  output logic              start_seen_o,
  output logic              stop_seen_o
);
  rx_state_e state_q, state_d;
  logic addr_ph_q, addr_ph_d;
  logic ack_q, ack_d;
  logic load, ovf_set, irq_set, rel_clr, at_set, at_clr;
  logic addr_match, accept, hold_sel;

  logic [BYTE_W-1:0] data_q;
  logic full_q, ovf_q, irq_q, rel_q, at_q, sseen_q, pseen_q;

  assign addr_match = (rx_byte_i == {own_addr_i, 1'b0});
  assign accept     = !ovf_q && (!full_q || buf_ovr_en_i);
  assign hold_sel   = addr_ph_q ? addr_hold_en_i : data_hold_en_i;

  always_comb begin
    state_d     = state_q;
    addr_ph_d   = addr_ph_q;
    ack_d       = ack_q;
    load        = 1'b0;
    ovf_set     = 1'b0;
    irq_set     = 1'b0;
    rel_clr     = 1'b0;
    at_set      = 1'b0;
    at_clr      = 1'b0;
    next_byte_o = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
      at_clr  = 1'b1;
      irq_set = stop_irq_en_i;
    end else if (start_i) begin
      state_d     = ST_RECV;
      addr_ph_d   = 1'b1;
      next_byte_o = 1'b1;
      at_clr      = 1'b1;
      irq_set     = start_irq_en_i;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (done_i) begin
            if (addr_ph_q && !addr_match) begin
              state_d = ST_SKIP;
            end else begin
              load    = accept;
              ovf_set = !accept && full_q && !buf_ovr_en_i;
              if (accept && hold_sel) begin
                state_d = ST_HOLD8;
                irq_set = 1'b1;
                at_set  = 1'b1;
                rel_clr = 1'b1;
              end else begin
                state_d = ST_ACK;
                ack_d   = accept;
              end
            end
          end
        end
        ST_HOLD8: begin
          if (rel_q) begin
            state_d = ST_ACK;
            ack_d   = !ack_data_i;
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            at_clr = 1'b1;
            if (ack_q) begin
              irq_set     = 1'b1;
              addr_ph_d   = 1'b0;
              next_byte_o = 1'b1;
              if (stretch_en_i) begin
                state_d = ST_HOLD9;
                rel_clr = 1'b1;
              end else begin
                state_d = ST_RECV;
              end
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_HOLD9: if (rel_q) state_d = ST_RECV;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_ph_q <= 1'b1;
      ack_q     <= 1'b0;
      data_q    <= '0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      irq_q     <= 1'b0;
      rel_q     <= 1'b1;
      at_q      <= 1'b0;
      sseen_q   <= 1'b0;
      pseen_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      addr_ph_q <= addr_ph_d;
      ack_q     <= ack_d;
      if (load) data_q <= rx_byte_i;
      if (load) full_q <= 1'b1;
      else if (rd_buf_i) full_q <= 1'b0;
      if (ovf_set) ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
      if (irq_set) irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (rel_clr) rel_q <= 1'b0;
      else if (release_i) rel_q <= 1'b1;
      if (at_set) at_q <= 1'b1;
      else if (at_clr) at_q <= 1'b0;
      if (stop_i) begin
        pseen_q <= 1'b1;
        sseen_q <= 1'b0;
      end else if (start_i) begin
        sseen_q <= 1'b1;
        pseen_q <= 1'b0;
      end
    end
  end

  assign scl_oe_o     = (state_q == ST_HOLD8) || (state_q == ST_HOLD9);
  assign sda_oe_o     = (state_q == ST_ACK) && ack_q;
  assign rx_data_o    = data_q;
  assign buf_full_o   = full_q;
  assign ovf_o        = ovf_q;
  assign irq_o        = irq_q;
  assign clk_rel_o    = rel_q;
  assign ack_time_o   = at_q;
  assign start_seen_o = sseen_q;
  assign stop_seen_o  = pseen_q;
endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold
  import i2c_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr_hold_en_i,
  input  logic              data_hold_en_i,
  input  logic              stretch_en_i,
  input  logic              buf_ovr_en_i,
  input  logic              start_irq_en_i,
  input  logic              stop_irq_en_i,
  input  logic              ack_data_i,
  input  logic              release_i,
  input  logic              rd_buf_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              clk_rel_o,
  output logic              ack_time_o,
  output logic              start_seen_o,
  output logic              stop_seen_o
);
  logic scl_rise, scl_fall, start_ev, stop_ev, done, next_byte;
  logic [BYTE_W-1:0] rx_byte;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_rx_shift #(.BYTE_W(BYTE_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (next_byte),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .byte_o     (rx_byte),
    .done_o     (done)
  );

  i2c_rx_ctrl i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .scl_fall_i     (scl_fall),
    .start_i        (start_ev),
    .stop_i         (stop_ev),
    .done_i         (done),
    .rx_byte_i      (rx_byte),
    .own_addr_i     (own_addr_i),
    .addr_hold_en_i (addr_hold_en_i),
    .data_hold_en_i (data_hold_en_i),
    .stretch_en_i   (stretch_en_i),
    .buf_ovr_en_i   (buf_ovr_en_i),
    .start_irq_en_i (start_irq_en_i),
    .stop_irq_en_i  (stop_irq_en_i),
    .ack_data_i     (ack_data_i),
    .release_i      (release_i),
    .rd_buf_i       (rd_buf_i),
    .irq_clr_i      (irq_clr_i),
    .ovf_clr_i      (ovf_clr_i),
    .next_byte_o    (next_byte),
    .scl_oe_o       (scl_oe_o),
    .sda_oe_o       (sda_oe_o),
    .rx_data_o      (rx_data_o),
    .buf_full_o     (buf_full_o),
    .ovf_o          (ovf_o),
    .irq_o          (irq_o),
    .clk_rel_o      (clk_rel_o),
    .ack_time_o     (ack_time_o),
    .start_seen_o   (start_seen_o),
    .stop_seen_o    (stop_seen_o)
  );
endmodule

// File: rtl/i2c_rx_hold_chk.sv
module i2c_rx_hold_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       rd_buf_i,
  input logic       irq_clr_i,
  input logic [7:0] rx_data_o,
  input logic       buf_full_o,
  input logic       ovf_o,
  input logic       irq_o,
  input logic       clk_rel_o,
  input logic       ack_time_o,
  input logic       start_seen_o,
  input logic       stop_seen_o
);
  AST_REL_LOW_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_rel_o |-> scl_oe_o); // R8
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $stable(rx_data_o)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R7
  AST_FULL_CLR_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_full_o) |-> $past(rd_buf_i)); // R11
  AST_ACKTIME_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_time_o) |-> scl_oe_o && !clk_rel_o); // R9
  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o)); // R2
endmodule

bind i2c_rx_hold i2c_rx_hold_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_oe_o     (scl_oe_o),
  .rd_buf_i     (rd_buf_i),
  .irq_clr_i    (irq_clr_i),
  .rx_data_o    (rx_data_o),
  .buf_full_o   (buf_full_o),
  .ovf_o        (ovf_o),
  .irq_o        (irq_o),
  .clk_rel_o    (clk_rel_o),
  .ack_time_o   (ack_time_o),
  .start_seen_o (start_seen_o),
  .stop_seen_o  (stop_seen_o)
);

// File: tb/test_i2c_rx_hold.sv
`timescale 1ns/1ps
module test_i2c_rx_hold;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_w, sda_w;
  logic ah = 0, dh = 0, st = 0, ovr = 0, sie = 0, pie = 0, ackd_in = 0;
  logic rel = 0, rdb = 0, iclr = 0, oclr = 0;
  logic [7:0] rx_data;
  logic full, ovf, irq, crel, atime, sseen, pseen;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign scl_w = !(m_scl_low || scl_oe);
  assign sda_w = !(m_sda_low || sda_oe);

  i2c_rx_hold i_i2c_rx_hold (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .addr_hold_en_i(ah), .data_hold_en_i(dh), .stretch_en_i(st),
    .buf_ovr_en_i(ovr), .start_irq_en_i(sie), .stop_irq_en_i(pie),
    .ack_data_i(ackd_in), .release_i(rel), .rd_buf_i(rdb),
    .irq_clr_i(iclr), .ovf_clr_i(oclr), .rx_data_o(rx_data),
    .buf_full_o(full), .ovf_o(ovf), .irq_o(irq), .clk_rel_o(crel),
    .ack_time_o(atime), .start_seen_o(sseen), .stop_seen_o(pseen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_w) @(negedge clk);
  endtask

  task automatic pulse_rel();  rel = 1;  @(negedge clk); rel = 0;  wait_clks(2); endtask
  task automatic pulse_rd();   rdb = 1;  @(negedge clk); rdb = 0;  endtask
  task automatic pulse_iclr(); iclr = 1; @(negedge clk); iclr = 0; endtask
  task automatic pulse_oclr(); oclr = 1; @(negedge clk); oclr = 0; endtask

  task automatic bus_start();
    m_sda_low = 0; wait_clks(Q); m_scl_low = 0; wait_scl_high(); wait_clks(Q);
    m_sda_low = 1; wait_clks(Q); m_scl_low = 1; wait_clks(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1; wait_clks(Q); m_scl_low = 0; wait_scl_high(); wait_clks(Q);
    m_sda_low = 0; wait_clks(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = !b; wait_clks(Q); m_scl_low = 0; wait_scl_high(); wait_clks(Q);
    m_scl_low = 1; wait_clks(Q);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // ninth bit: returns 1 when the target pulled SDA low
  task automatic ack_clock(output logic acked);
    m_sda_low = 0; wait_clks(Q); m_scl_low = 0; wait_scl_high(); wait_clks(Q/2);
    acked = !sda_w; wait_clks(Q/2); m_scl_low = 1; wait_clks(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic a_ok;
    wait_clks(3);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {full, ovf, irq, atime, sseen, pseen}, 0);
    chk("R1 clk_rel", crel, 1);
    rst_n = 1; wait_clks(Q);

    // R2 start/stop status and interrupt enables
    for (int c = 0; c < 4; c++) begin
      sie = c[0]; pie = c[1];
      bus_start();
      chk("R2 start seen", {sseen, pseen}, 2'b10);
      chk("R2 start irq", irq, sie);
      pulse_iclr();
      bus_stop();
      chk("R2 stop seen", {sseen, pseen}, 2'b01);
      chk("R2 stop irq", irq, pie);
      pulse_iclr();
    end
    sie = 0; pie = 0;

    // R3 exhaustive address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      logic [7:0] ab;
      logic m;
      ab = {7'(a), 1'b0};
      m = (7'(a) == OWN);
      bus_start(); send_byte(ab); ack_clock(a_ok);
      chk("R3 addr ack", a_ok, m);
      chk("R3 buf_full", full, m);
      chk("R7 irq after addr", irq, m);
      if (m) begin
        chk("R3 buffer", rx_data, ab);
        wait_clks(20);
        chk("R7 irq sticky", irq, 1);
        pulse_rd(); chk("R11 rd clears full", full, 0);
        pulse_iclr(); chk("R7 irq cleared", irq, 0);
      end
      bus_stop();
    end
    // read direction to own address is refused
    bus_start(); send_byte({OWN, 1'b1}); ack_clock(a_ok);
    chk("R3 rw=1 nack", a_ok, 0); chk("R3 rw=1 no load", full, 0);
    bus_stop();

    // R4 data bytes, R5 overflow
    bus_start(); send_byte({OWN, 1'b0}); ack_clock(a_ok); pulse_rd(); pulse_iclr();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 5);
      send_byte(d); ack_clock(a_ok);
      chk("R4 data ack", a_ok, 1); chk("R4 data", rx_data, d);
      chk("R4 full", full, 1); chk("R7 irq data", irq, 1);
      pulse_rd(); pulse_iclr();
    end
    send_byte(8'hC3); ack_clock(a_ok); pulse_iclr();
    chk("R4 ack C3", a_ok, 1);
    send_byte(8'h3C); ack_clock(a_ok);
    chk("R5 ovf nack", a_ok, 0); chk("R5 ovf set", ovf, 1);
    chk("R5 buffer kept", rx_data, 8'hC3); chk("R7 no irq on nack", irq, 0);
    bus_stop(); pulse_rd();
    bus_start(); send_byte({OWN, 1'b0}); ack_clock(a_ok);
    chk("R5 nack while ovf", a_ok, 0); chk("R5 no load while ovf", full, 0);
    chk("R5 buffer kept 2", rx_data, 8'hC3);
    bus_stop(); pulse_oclr(); pulse_iclr();

    // R6 buffer override
    ovr = 1;
    bus_start(); send_byte({OWN, 1'b0}); ack_clock(a_ok); pulse_iclr();
    send_byte(8'h96); ack_clock(a_ok);
    chk("R6 override ack", a_ok, 1); chk("R6 override data", rx_data, 8'h96);
    chk("R6 no ovf", ovf, 0);
    bus_stop(); pulse_rd(); pulse_iclr(); ovr = 0;

    // R8 R9 R10 hold/stretch sweep
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int nk = 0; nk < 2; nk++) begin
        logic [7:0] d;
        logic exp_ack;
        ah = cfg[0]; dh = cfg[1]; st = cfg[2]; ackd_in = 0;
        d = {3'(cfg), 1'(nk), 4'hA};
        bus_start(); send_byte({OWN, 1'b0});
        chk("R9 addr hold irq", irq, ah); chk("R9 addr ack_time", atime, ah);
        chk("R9 addr clk_rel", crel, !ah); chk("R9 addr scl held", scl_oe, ah);
        if (ah) begin pulse_iclr(); pulse_rel(); end
        ack_clock(a_ok);
        chk("R3 addr ack in sweep", a_ok, 1); chk("R7 irq addr 9th", irq, 1);
        chk("R10 ack_time cleared", atime, 0);
        chk("R8 stretch addr", scl_oe, st); chk("R8 clk_rel addr", crel, !st);
        pulse_rd(); pulse_iclr();
        if (st) begin
          wait_clks(30); chk("R8 still held", scl_oe, 1);
          pulse_rel(); chk("R8 released", scl_oe, 0);
        end
        ackd_in = 1'(nk);
        send_byte(d);
        chk("R9 data hold irq", irq, dh); chk("R9 data ack_time", atime, dh);
        chk("R9 data scl held", scl_oe, dh);
        if (dh) begin
          chk("R9 data visible in hold", rx_data, d);
          pulse_iclr(); pulse_rel();
        end
        exp_ack = dh ? !nk[0] : 1'b1;
        ack_clock(a_ok);
        chk("R9 data ack level", a_ok, exp_ack);
        chk("R7 irq data 9th", irq, exp_ack);
        chk("R10 ack_time data", atime, 0);
        chk("R8 stretch data", scl_oe, exp_ack && st);
        if (exp_ack && st) pulse_rel();
        pulse_iclr(); pulse_rd(); ackd_in = 0;
        bus_stop();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule